// File: doc/BRIEF.md
# Processor I/O Port with Floating-Bit Charge Hold

This block is the small I/O port built into an 8-bit processor, seen through a synchronous register bus at two addresses. One register sets the direction of each port bit (1 = drive), the other holds the value to drive. From these the block keeps the port pin state, produces a 3-bit control word that the memory-banking logic decodes, and gives back a composed byte when the data register is read. That byte mixes the pin state with fixed pull-ups on some bits and a forced-low bit.

Bits 6 and 7 of the port have no pins. When they are made inputs, they float. A read of such a bit gives back the last value that was driven onto it, and only until its stored charge leaks away. Each of these two bits has a charge cell: a small state machine with states `S_EMPTY` (no charge, reads 0) and `S_HELD` (value kept, timer running). Transition `T_LOAD` moves any state to `S_HELD`, reloads the timer and captures a value. Transition `T_DECAY` moves `S_HELD` to `S_EMPTY` once the timer has counted down to zero, and clears the value. The timer counts down once per pulse of the free-running cycle tick. The interval is the parameter `FALL_CYCLES`, with a default of 350000.

Top module: `cpu_io_port`

## Requirements
- R1: Address 0 selects the direction register and address 1 selects the data register. Any other address reads as 0x00, and a write to it changes no register, pin or charge.
- R2: After reset the direction is 0x00, the data is 0x3F and the pins are 0x3F. Both charge cells are `S_EMPTY`, so a read of address 1 gives 0x1F and `bank_ctl` is 7.
- R3: On every clock edge, each pin whose direction bit is 1 takes the new data bit. Each pin whose direction bit is 0 keeps its previous value.
- R4: For bits 0 to 5, a read of address 1 gives (data | ~dir) & (pins | 0x17). Bit 5 is then forced to 0 while direction bit 5 is 0. Bit 4 is never forced low.
- R5: `bank_ctl` is bits 2:0 of (data | ~dir). It follows every register write on the edge that performs it.
- R6: A write to address 1 while direction bit 6 (or 7) is 1 fires `T_LOAD` on that bit's cell. The cell captures the written bit and restarts its timer at `FALL_CYCLES`.
- R7: A write to address 0 that turns direction bit 6 (or 7) from 1 to 0 fires `T_LOAD` on that bit's cell, capturing the current data-register bit.
- R8: A captured 1 reads back for exactly `FALL_CYCLES` tick pulses after the `T_LOAD` edge and reads 0 afterwards (`T_DECAY`). Cycles without a tick do not count toward the interval.
- R9: When direction bit 6 (or 7) is 0, that bit of an address-1 read comes from the charge cell. When it is 1, the bit follows the R4 expression.
- R10: A write to address 1 while direction bit 6 (or 7) is 0 leaves that bit's charge cell unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One pulse per processor cycle; advances the charge timers |
| addr | input | ADDR_W | Register bus address |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| port_pins | output | 8 | Port pin state |
| bank_ctl | output | 3 | Memory-banking control word |

## Verification
On every cycle the assertions check these behaviours:
- driven pins match the data register;
- forced-low bit 5 on reads;
- the effect of each `T_LOAD` on the cell state, timer and captured value;
- `T_DECAY` clearing the value;
- the timer holding still between ticks.

The exact expiry boundary at `FALL_CYCLES` ticks and the reads of floating bits after direction changes can only be shown by bench scenarios. So can the effect of ignored writes to address 1 or to undecoded addresses. The bench checks all of these against a reference model of the requirements. It uses random bus traffic and directed cases.

// File: rtl/cpu_io_port_pkg.sv
package cpu_io_port_pkg;

    localparam int unsigned PORT_W     = 8;
    localparam int unsigned BANK_W     = 3;
    localparam int unsigned FLOAT_LO   = 6;  // first pinless bit
    localparam int unsigned FLOAT_N    = 2;  // bits 6 and 7
    localparam logic [7:0]  PULLUP_MSK = 8'h17;
    localparam logic [7:0]  RST_DATA   = 8'h3F;
    localparam logic [7:0]  RST_PINS   = 8'h3F;
    localparam int unsigned FORCE_BIT  = 5;

    typedef enum logic [0:0] {
        S_EMPTY = 1'b0,
        S_HELD  = 1'b1
    } cell_state_e;

endpackage

// File: rtl/charge_cell.sv
module charge_cell
    import cpu_io_port_pkg::*;
#(
    parameter int unsigned FALL_CYCLES = 350000,
    localparam int unsigned CNT_W      = $clog2(FALL_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  logic load_val,
    output logic held_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FALL_CYCLES);

    cell_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             val_q;
    logic             t_decay;

    assign t_decay = (state_q == S_HELD) && (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: if (load) state_d = S_HELD;
            S_HELD: begin
                if (load)         state_d = S_HELD;   // T_LOAD restarts
                else if (t_decay) state_d = S_EMPTY;  // T_DECAY
            end
            default: state_d = S_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    // timer and captured value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            val_q <= 1'b0;
        end else if (load) begin
            cnt_q <= CNT_LOAD;
            val_q <= load_val;
        end else if (t_decay) begin
            val_q <= 1'b0;
        end else if (state_q == S_HELD && tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs: value is visible only while the timer has not run out
    always_comb begin
        unique case (state_q)
            S_HELD:  held_o = val_q && (cnt_q != '0);
            default: held_o = 1'b0;
        endcase
    end

    p_load_captures_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == S_HELD) && (cnt_q == CNT_LOAD) && (val_q == $past(load_val)));

    p_decay_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_decay && !load) |=> (state_q == S_EMPTY) && !val_q && !held_o);

    p_pause_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HELD && !tick && !load && cnt_q != '0) |=> $stable(cnt_q));

endmodule

// File: rtl/port_regs.sv
module port_regs
    import cpu_io_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_data,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] pins_q
);

    logic [PORT_W-1:0] dir_d, data_d;

    always_comb begin
        dir_d  = wr_dir  ? wdata : dir_q;
        data_d = wr_data ? wdata : data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= RST_DATA;
            pins_q <= RST_PINS;
        end else begin
            dir_q  <= dir_d;
            data_q <= data_d;
            pins_q <= (pins_q & ~dir_d) | (data_d & dir_d);
        end
    end

    p_driven_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pins_q ^ data_q) & dir_q) == '0);

    p_input_pins_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_dir) |=> ((pins_q ^ $past(pins_q)) & ~dir_q) == '0);

endmodule

// File: rtl/cpu_io_port.sv
module cpu_io_port
    import cpu_io_port_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned FALL_CYCLES = 350000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [7:0]        port_pins,
    output logic [2:0]        bank_ctl
);

    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);

    logic              sel_dir, sel_data;
    logic [PORT_W-1:0] dir_q, data_q, pins_q;
    logic [PORT_W-1:0] drive_or_pull;
    logic [PORT_W-1:0] base_rd, port_rd;
    logic [FLOAT_N-1:0] held;

    assign sel_dir  = (addr == A_DIR);
    assign sel_data = (addr == A_DATA);

    port_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_en && sel_dir),
        .wr_data (wr_en && sel_data),
        .wdata   (wdata),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .pins_q  (pins_q)
    );

    for (genvar g = 0; g < FLOAT_N; g++) begin : g_float
        localparam int unsigned B = FLOAT_LO + g;
        logic ld_from_bus, ld_from_turn, ld, ld_val;

        assign ld_from_bus  = wr_en && sel_data && dir_q[B];
        assign ld_from_turn = wr_en && sel_dir && dir_q[B] && !wdata[B];
        assign ld           = ld_from_bus || ld_from_turn;
        assign ld_val       = ld_from_bus ? wdata[B] : data_q[B];

        charge_cell #(.FALL_CYCLES(FALL_CYCLES)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .load     (ld),
            .load_val (ld_val),
            .held_o   (held[g])
        );
    end

    assign drive_or_pull = data_q | ~dir_q;
    assign bank_ctl      = drive_or_pull[BANK_W-1:0];
    assign port_pins     = pins_q;

    always_comb begin
        base_rd = drive_or_pull & (pins_q | PULLUP_MSK);
        if (!dir_q[FORCE_BIT]) base_rd[FORCE_BIT] = 1'b0;
        port_rd = base_rd;
        for (int i = 0; i < FLOAT_N; i++) begin
            if (!dir_q[FLOAT_LO + i]) port_rd[FLOAT_LO + i] = held[i];
        end
    end

    always_comb begin
        if (sel_dir)       rdata = dir_q;
        else if (sel_data) rdata = port_rd;
        else               rdata = '0;
    end

    p_bit5_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_data && !dir_q[FORCE_BIT]) |-> !rdata[FORCE_BIT]);

    p_undecoded_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_dir && !sel_data) |=> $stable(port_pins) && $stable(bank_ctl));

    p_bank_follows_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_data && (dir_q & 8'h07) == 8'h07) |=> bank_ctl == $past(wdata[2:0]));

endmodule

// File: tb/test_cpu_io_port.sv
module test_cpu_io_port;

    localparam int FALL = 40;
    localparam int AW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata, port_pins;
    logic [2:0]    bank_ctl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_dir, m_data, m_pins;
    logic [1:0] m_ch, m_hv;
    int         m_cnt [2];

    always #5 clk = ~clk;

    cpu_io_port #(.ADDR_W(AW), .FALL_CYCLES(FALL)) i_cpu_io_port (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .port_pins(port_pins), .bank_ctl(bank_ctl)
    );

    function automatic logic eff_held(int i);
        return m_ch[i] && (m_cnt[i] != 0) ? m_hv[i] : 1'b0;
    endfunction

    function automatic logic [7:0] exp_read(logic [AW-1:0] a);
        logic [7:0] v;
        if (a == 0) return m_dir;
        if (a != 1) return 8'h00;
        v = (m_data | ~m_dir) & (m_pins | 8'h17);
        if (!m_dir[5]) v[5] = 1'b0;
        for (int i = 0; i < 2; i++) if (!m_dir[6+i]) v[6+i] = eff_held(i);
        return v;
    endfunction

    task automatic model_reset();
        m_dir = 8'h00; m_data = 8'h3F; m_pins = 8'h3F;
        m_ch = 2'b00; m_hv = 2'b00; m_cnt[0] = 0; m_cnt[1] = 0;
    endtask

    task automatic model_edge(logic w, logic [AW-1:0] a, logic [7:0] d, logic t);
        logic [7:0] nd, nt;
        nd = m_dir; nt = m_data;
        for (int i = 0; i < 2; i++) begin
            int b = 6 + i;
            logic ld, lv;
            ld = 1'b0; lv = 1'b0;
            if (w && a == 1 && m_dir[b]) begin ld = 1'b1; lv = d[b]; end
            if (w && a == 0 && m_dir[b] && !d[b]) begin ld = 1'b1; lv = m_data[b]; end
            if (ld) begin m_ch[i] = 1'b1; m_hv[i] = lv; m_cnt[i] = FALL; end
            else if (m_ch[i]) begin
                if (m_cnt[i] == 0) begin m_ch[i] = 1'b0; m_hv[i] = 1'b0; end
                else if (t) m_cnt[i] = m_cnt[i] - 1;
            end
        end
        if (w && a == 0) nd = d;
        if (w && a == 1) nt = d;
        m_dir = nd; m_data = nt;
        m_pins = (m_pins & ~nd) | (nt & nd);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // drive inputs at negedge, check the reference model, then take the edge
    task automatic step(logic w, logic [AW-1:0] a, logic [7:0] d, logic t);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; tick = t;
        #1;
        chk("R4 R9 R1 rdata", rdata, exp_read(a));
        chk("R3 pins", port_pins, m_pins);
        chk("R5 bank_ctl", {5'b0, bank_ctl}, {5'b0, 3'((m_data | ~m_dir) & 8'h07)});
        @(posedge clk);
        model_edge(w, a, d, t);
    endtask

    task automatic peek(logic [AW-1:0] a, string req, logic [7:0] exp);
        @(negedge clk);
        wr_en = 1'b0; addr = a; tick = 1'b0;
        #1;
        chk(req, rdata, exp);
        @(posedge clk);
        model_edge(1'b0, a, 8'h00, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state
        peek(1, "R2 reset read", 8'h1F);
        peek(0, "R2 reset dir", 8'h00);
        chk("R2 reset pins", port_pins, 8'h3F);
        chk("R2 reset bank", {5'b0, bank_ctl}, 8'h07);

        // R6/R8: charge bit 7 with a 1, then turn it to input, count boundary
        step(1, 0, 8'h80, 0);
        step(1, 1, 8'hBF, 0);     // data bit7=1, loads held=1
        step(1, 0, 8'h00, 0);     // R7: out->in, loads data bit7 = 1
        for (int k = 0; k < FALL - 1; k++) step(0, 1, 8'h00, 1);
        peek(1, "R8 held one before expiry", {1'b1, exp_read(1) & 8'h7F} | 8'h80);
        step(0, 1, 8'h00, 1);
        peek(1, "R8 expired to zero", exp_read(1) & 8'h7F);

        // R8: no tick pauses the timer
        step(1, 0, 8'h40, 0);
        step(1, 1, 8'h40, 0);
        step(1, 0, 8'h00, 0);
        repeat (FALL + 10) step(0, 2, 8'h00, 0);
        peek(1, "R8 paused timer keeps bit6", exp_read(1) | 8'h40);

        // R10: write while input does not charge
        step(1, 1, 8'h00, 0);
        peek(1, "R10 input write leaves bit6", exp_read(1) | 8'h40);

        // R1: undecoded write changes nothing
        step(1, 16'h0002, 8'hFF, 0);
        step(1, 16'h8001, 8'hFF, 0);
        peek(0, "R1 dir unchanged", 8'h00);
        peek(16'h0100, "R1 undecoded read", 8'h00);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            int r;
            r = $urandom_range(0, 9);
            a = (r < 4) ? AW'(0) : (r < 8) ? AW'(1) : AW'($urandom_range(2, 65535));
            step(($urandom_range(0, 3) == 0), a, 8'($urandom), ($urandom_range(0, 7) != 0));
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule